// File: doc/BRIEF.md
# Display Word Buffer with Fetch-Wakeup Control

This block is a small first-in, first-out store of display words that sits between the microcoded task that fetches bitmap words from memory and the pixel shifter that serialises them onto a scanline. Processor stores put words in through a write counter. The shifter's unload strobe takes words out through a read counter. Both counters are four bits wide and wrap around. A status decode is formed from the two counters. It tells the fetch task when to stop asking for words and tells the shifter when nothing is left.

The block also produces the wakeup request for the word-fetch task. It raises the request only while three conditions hold: the fetch task has not blocked itself, the horizontal task has not blocked, and the buffer has room. A scan-end pulse from the line sequencer withdraws the request. Every rising edge of horizontal sync flushes the buffer, clears the fetch-task block flag and clears the overflow flag, so each scanline starts clean. When the shifter unloads from an empty buffer it receives only the background pattern, either all zeros or all ones under the invert control.

Top module: `disp_word_buf`

## Requirements
- R1: Words leave in the order they were stored. One cycle after an unload that finds the buffer non-empty, `pix_valid` is 1 and `pix_word` equals the stored word XOR the background mask. The mask is 16'hFFFF when `bg_invert`=1 and 16'h0000 otherwise.
- R2: The read and write counters are 4 bits wide and wrap from 15 to 0. The buffer stays correct over more than 16 stores and unloads.
- R3: The status decode is addressed by the bit-reversed write counter in the upper four address bits and the bit-reversed read counter in the lower four. `empty_n` is 0 exactly when the two counters are equal.
- R4: `stop_wake_n` is 0 whenever the buffer holds 14 or more words, and 1 otherwise.
- R5: An unload while the buffer is empty is an underrun. One cycle later `pix_valid`=1, `underrun`=1 and `pix_word` equals the background mask. The read counter does not advance, so the next stored word is the next word unloaded.
- R6: The buffer is full at 15 words. A store while full is dropped, and the sticky `overflow` output goes to 1.
- R7: A rising edge of `hsync` sets both counters to zero, clears the fetch-task block flag and clears `overflow`. A store or unload in that same cycle is dropped.
- R8: `wake_req` is registered. It is 1 one cycle after a cycle in which the fetch task was not blocked, `ht_blocked` was 0, `stop_wake_n` was 1 and `scan_end` was 0.
- R9: A one-cycle pulse on `wt_block` blocks the fetch task. It stays blocked, and `wake_req` stays 0, until the next rising edge of `hsync`.
- R10: A `scan_end` pulse makes `wake_req` 0 in the following cycle, even when every other condition allows a request.
- R11: After reset, `pix_valid`, `underrun`, `overflow` and `wake_req` are 0, `empty_n` is 0 and `stop_wake_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | Horizontal sync level; its rising edge flushes the buffer |
| scan_end | input | 1 | End-of-scan pulse; withdraws the wakeup request |
| st_en | input | 1 | Store strobe from the processor |
| st_word | input | 16 | Word being stored |
| unload | input | 1 | Unload strobe from the pixel shifter |
| bg_invert | input | 1 | Selects the all-ones background mask |
| wt_block | input | 1 | Fetch task executed a block (pulse) |
| ht_blocked | input | 1 | Horizontal task is blocked (level) |
| pix_word | output | 16 | Word handed to the shifter |
| pix_valid | output | 1 | `pix_word` was updated by an unload in the previous cycle |
| underrun | output | 1 | The last unload found the buffer empty |
| empty_n | output | 1 | Low when the buffer is empty |
| stop_wake_n | output | 1 | Low when the buffer holds 14 or more words |
| overflow | output | 1 | Sticky flag: a store was dropped because the buffer was full |
| wake_req | output | 1 | Wakeup request for the word-fetch task |

## Verification
If a counter drifts, the shifter's words come out of order, repeated or missing. The mismatch shows on `pix_word` at the very next unload. A status decode that is off by one word shows on `empty_n` or `stop_wake_n` at the cycle the occupancy crosses 0, 14 or 15. It also shows on `wake_req` one cycle later. A flush or block flag that is not cleared shows as `wake_req` staying low for a whole line after `hsync` rises.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
    localparam int PTR_W_DEF  = 4;
    localparam int WORD_W_DEF = 16;
    localparam int STOP_DEF   = 14;

    typedef struct packed {
        logic stop_wake_n;
        logic empty_n;
        logic full;
    } dwb_stat_t;

    typedef struct packed {
        logic st_fire;
        logic ld_fire;
        logic flush;
    } dwb_ctl_t;
endpackage

// File: rtl/dwb_ptrs.sv
module dwb_ptrs
    import dwb_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  dwb_ctl_t         ctl,
    input  logic             st_req,
    input  dwb_stat_t        stat,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             overflow
);
    always_ff @(posedge clk) begin
        if (rst || ctl.flush) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            overflow <= 1'b0;
        end else begin
            if (ctl.st_fire) wr_ptr <= wr_ptr + 1'b1;
            if (ctl.ld_fire) rd_ptr <= rd_ptr + 1'b1;
            if (st_req && stat.full) overflow <= 1'b1;
        end
    end

    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.flush |=> (rd_ptr == '0 && wr_ptr == '0 && !overflow)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (st_req && stat.full && !ctl.flush) |=> ($stable(wr_ptr) && overflow)); // R6
    AST_UNDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!stat.empty_n && !ctl.st_fire && !ctl.flush) |=> $stable(rd_ptr)); // R5
endmodule

// File: rtl/dwb_status.sv
module dwb_status
    import dwb_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF,
    parameter int STOP  = STOP_DEF
) (
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] wr_ptr,
    output dwb_stat_t        stat
);
    localparam int AW    = 2 * PTR_W;
    localparam int DEPTH = 1 << PTR_W;

    logic [AW-1:0]    addr;
    logic [PTR_W-1:0] a_rd, a_wr, fill;

    // address lines are wired with each counter's bit order reversed
    for (genvar i = 0; i < PTR_W; i++) begin : g_rev
        assign addr[i]               = rd_ptr[PTR_W-1-i];
        assign addr[PTR_W+i]         = wr_ptr[PTR_W-1-i];
        assign a_rd[PTR_W-1-i]       = addr[i];
        assign a_wr[PTR_W-1-i]       = addr[PTR_W+i];
    end

    assign fill = a_wr - a_rd;

    always_comb begin
        stat.empty_n     = (a_rd != a_wr);
        stat.stop_wake_n = !(32'(fill) >= STOP);
        stat.full        = (32'(fill) == DEPTH - 1);
    end
endmodule

// File: rtl/dwb_store.sv
module dwb_store
    import dwb_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  dwb_ctl_t          ctl,
    input  logic              ld_req,
    input  logic              empty_n,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] st_word,
    input  logic              bg_invert,
    output logic [WORD_W-1:0] pix_word,
    output logic              pix_valid,
    output logic              underrun
);
    localparam int DEPTH = 1 << PTR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] mask;

    assign mask = {WORD_W{bg_invert}};

    always_ff @(posedge clk) begin
        if (ctl.st_fire) mem[wr_ptr] <= st_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_word  <= '0;
            pix_valid <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            pix_valid <= ld_req && !ctl.flush;
            underrun  <= ld_req && !ctl.flush && !empty_n;
            if (ld_req && !ctl.flush)
                pix_word <= empty_n ? (mem[rd_ptr] ^ mask) : mask;
        end
    end

    AST_UNDER_MASK: assert property (@(posedge clk) disable iff (rst)
        underrun |-> (pix_valid && (pix_word == {WORD_W{$past(bg_invert)}}))); // R5
endmodule

// File: rtl/dwb_wake.sv
module dwb_wake
    import dwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hsync,
    input  logic      scan_end,
    input  logic      wt_block,
    input  logic      ht_blocked,
    input  dwb_stat_t stat,
    output logic      flush,
    output logic      wake_req
);
    logic hsync_q, wt_blk;

    assign flush = hsync && !hsync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_q  <= 1'b0;
            wt_blk   <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            hsync_q  <= hsync;
            if (flush)         wt_blk <= 1'b0;
            else if (wt_block) wt_blk <= 1'b1;
            wake_req <= !wt_blk && !ht_blocked && stat.stop_wake_n && !scan_end;
        end
    end

    AST_SCANEND_DROP: assert property (@(posedge clk) disable iff (rst)
        scan_end |=> !wake_req); // R10
    AST_STOP_DROP: assert property (@(posedge clk) disable iff (rst)
        !stat.stop_wake_n |=> !wake_req); // R4
    AST_HT_DROP: assert property (@(posedge clk) disable iff (rst)
        ht_blocked |=> !wake_req); // R8
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wt_block && !flush) |=> ##1 !wake_req); // R9
endmodule

// File: rtl/disp_word_buf.sv
module disp_word_buf
    import dwb_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int STOP   = STOP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              scan_end,
    input  logic              st_en,
    input  logic [WORD_W-1:0] st_word,
    input  logic              unload,
    input  logic              bg_invert,
    input  logic              wt_block,
    input  logic              ht_blocked,
    output logic [WORD_W-1:0] pix_word,
    output logic              pix_valid,
    output logic              underrun,
    output logic              empty_n,
    output logic              stop_wake_n,
    output logic              overflow,
    output logic              wake_req
);
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    dwb_stat_t        stat;
    dwb_ctl_t         ctl;
    logic             flush;

    always_comb begin
        ctl.flush   = flush;
        ctl.st_fire = st_en && !stat.full && !flush;
        ctl.ld_fire = unload && stat.empty_n && !flush;
    end

    dwb_status #(.PTR_W(PTR_W), .STOP(STOP)) u_status (
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .stat(stat)
    );

    dwb_ptrs #(.PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst(rst), .ctl(ctl), .st_req(st_en), .stat(stat),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .overflow(overflow)
    );

    dwb_store #(.PTR_W(PTR_W), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst(rst), .ctl(ctl), .ld_req(unload), .empty_n(stat.empty_n),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .st_word(st_word), .bg_invert(bg_invert),
        .pix_word(pix_word), .pix_valid(pix_valid), .underrun(underrun)
    );

    dwb_wake u_wake (
        .clk(clk), .rst(rst), .hsync(hsync), .scan_end(scan_end),
        .wt_block(wt_block), .ht_blocked(ht_blocked), .stat(stat),
        .flush(flush), .wake_req(wake_req)
    );

    assign empty_n     = stat.empty_n;
    assign stop_wake_n = stat.stop_wake_n;

    AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush |=> !empty_n); // R3
endmodule

// File: tb/sim_disp_word_buf.sv
module sim_disp_word_buf;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync = 0, scan_end = 0, st_en = 0, unload = 0, bg_invert = 0;
    logic wt_block = 0, ht_blocked = 0;
    logic [15:0] st_word = '0;
    logic [15:0] pix_word;
    logic pix_valid, underrun, empty_n, stop_wake_n, overflow, wake_req;

    always #10 clk = ~clk;

    disp_word_buf u0 (
        .clk(clk), .rst(rst), .hsync(hsync), .scan_end(scan_end),
        .st_en(st_en), .st_word(st_word), .unload(unload), .bg_invert(bg_invert),
        .wt_block(wt_block), .ht_blocked(ht_blocked), .pix_word(pix_word),
        .pix_valid(pix_valid), .underrun(underrun), .empty_n(empty_n),
        .stop_wake_n(stop_wake_n), .overflow(overflow), .wake_req(wake_req)
    );

    int total = 0, bad = 0;
    logic [15:0] content[$];
    logic [16:0] sb[$];
    logic m_ovf = 0;
    logic hs_prev = 0;
    logic done = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and updates the model
    task automatic step(input logic s, input logic [15:0] d, input logic u, input logic hs);
        int pre;
        pre = content.size();
        st_en = s; st_word = d; unload = u; hsync = hs;
        if (hs && !hs_prev) begin
            content.delete();
            m_ovf = 0;
        end else begin
            if (u) begin
                if (pre > 0) sb.push_back({1'b0, content.pop_front() ^ {16{bg_invert}}});
                else         sb.push_back({1'b1, {16{bg_invert}}});
            end
            if (s) begin
                if (pre < 15) content.push_back(d);
                else          m_ovf = 1;
            end
        end
        hs_prev = hs;
        @(negedge clk);
        st_en = 0; unload = 0;
    endtask

    task automatic check_status(input string tag);
        chk(empty_n == (content.size() != 0), {tag, " R3 empty_n"}, empty_n, content.size() != 0);
        chk(stop_wake_n == (content.size() < 14), {tag, " R4 stop_wake_n"}, stop_wake_n, content.size() < 14);
        chk(overflow == m_ovf, {tag, " R6 overflow"}, overflow, m_ovf);
    endtask

    // monitor: pops scoreboard on every output word
    always @(negedge clk) begin
        if (!rst && pix_valid) begin
            if (sb.size() == 0) chk(0, "R1 unexpected pix_valid", 1, 0);
            else begin
                logic [16:0] e;
                e = sb.pop_front();
                chk(pix_word == e[15:0], "R1/R5 pix_word", pix_word, e[15:0]);
                chk(underrun == e[16], "R5 underrun", underrun, e[16]);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        chk(!pix_valid && !underrun && !overflow && !wake_req, "R11 reset outputs", {pix_valid, underrun, overflow, wake_req}, 0);
        chk(!empty_n && stop_wake_n, "R11 reset status", {empty_n, stop_wake_n}, 2'b01);
        step(0, 0, 0, 0);
        chk(wake_req == 1, "R8 wake after reset", wake_req, 1);

        // R1 FIFO order, plain mask
        for (int i = 0; i < 3; i++) step(1, 16'h1230 + 16'(i), 0, 0);
        check_status("three");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        check_status("drained");

        // R1 inverted background
        bg_invert = 1;
        step(1, 16'h00F0, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);

        // R5 underrun then recovery
        step(0, 0, 1, 0);
        step(1, 16'hBEEF, 0, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        bg_invert = 0;

        // R2 wrap: many words through with simultaneous store/unload
        step(1, 16'h0001, 0, 0);
        for (int i = 0; i < 40; i++) step(1, 16'(i * 37 + 5), 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        check_status("wrap");

        // R4 stop threshold
        for (int i = 0; i < 13; i++) step(1, 16'(16'hA000 + i), 0, 0);
        check_status("13 words");
        step(0, 0, 0, 0);
        chk(wake_req == 1, "R8 wake at 13", wake_req, 1);
        step(1, 16'hA00D, 0, 0);
        check_status("14 words");
        step(0, 0, 0, 0);
        chk(wake_req == 0, "R4 wake off at 14", wake_req, 0);

        // R6 full and dropped store
        step(1, 16'hA00E, 0, 0);
        check_status("15 words");
        step(1, 16'hDEAD, 0, 0);
        check_status("dropped store");
        for (int i = 0; i < 15; i++) step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        check_status("after full drain");

        // R7 flush on rising hsync, store in same cycle dropped
        for (int i = 0; i < 15; i++) step(1, 16'(i), 0, 0);
        step(1, 16'h7777, 0, 0);
        chk(overflow == 1, "R6 overflow set", overflow, 1);
        step(1, 16'h5555, 0, 1);
        check_status("flush");
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        check_status("post flush");

        // R9 block flag held until flush
        wt_block = 1; step(0, 0, 0, 0); wt_block = 0;
        step(0, 0, 0, 0);
        chk(wake_req == 0, "R9 blocked", wake_req, 0);
        repeat (3) step(0, 0, 0, 0);
        chk(wake_req == 0, "R9 still blocked", wake_req, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk(wake_req == 1, "R7/R9 unblocked by flush", wake_req, 1);

        // R8 horizontal task block
        ht_blocked = 1; step(0, 0, 0, 0);
        chk(wake_req == 0, "R8 ht_blocked", wake_req, 0);
        ht_blocked = 0; step(0, 0, 0, 0);
        chk(wake_req == 1, "R8 ht released", wake_req, 1);

        // R10 scan end
        scan_end = 1; step(0, 0, 0, 0); scan_end = 0;
        chk(wake_req == 0, "R10 scan_end", wake_req, 0);
        step(0, 0, 0, 0);
        chk(wake_req == 1, "R10 recovered", wake_req, 1);

        step(0, 0, 0, 0);
        chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule